// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block watches the transmit enable of a 10 Mb/s MAC-to-PHY path. It guards the line against a stuck transmitter, and in half-duplex operation it gives the MAC a short collision-test pulse after each frame. If transmit enable stays high for too long, the block raises a transmit inhibit that blocks the line driver. It also holds the collision output high for as long as the inhibit lasts. The inhibit is released only after transmit enable has stayed low for a long, unbroken quiet interval.

When a frame ends normally in half-duplex mode, a short delay passes and then the collision output carries a fixed-length heartbeat pulse. A frame that ends while the transmitter is locked out does not produce this pulse.

Every interval is measured in ticks from a free-running prescaler that divides the clock by `TICK_DIV`. The defaults target a 100 MHz clock with a 100 ns tick: a trip after 85 ms, a release after 500 ms, a heartbeat that starts 600 ns after the end of the frame, and a heartbeat 1000 ns long. A simulation can shrink all of these intervals through the parameters.

Top module: `jtx_supervisor`

## Requirements
- R1: A synchronous active-high `rst` clears the lockout, any pending or active heartbeat and the stored previous `tx_en`. On the cycle after reset, `col` = 0 and `tx_inhibit` = 0.
- R2: Once `tx_en` has been sampled high on `JAB_TRIP_TICKS` consecutive ticks, `tx_inhibit` rises directly after the edge that took the last of those samples.
- R3: A `tx_en` burst shorter than `JAB_TRIP_TICKS` ticks never raises `tx_inhibit`. A single low sample resets the count of consecutive high samples.
- R4: For as long as `tx_inhibit` is 1, `col` is 1 as well.
- R5: The lockout ends after `tx_en` has been sampled low on `JAB_REL_TICKS` consecutive ticks. Any high sample during the lockout restarts that count, and high samples never add toward a release.
- R6: An end of transmission is an edge that samples `tx_en` = 0 when the previous edge sampled 1. If that edge also samples `full_duplex` = 0, `col` goes high `HB_DLY_TICKS` ticks after it and stays high for exactly `HB_LEN_TICKS` ticks.
- R7: An end of transmission that is sampled with `full_duplex` = 1 produces no heartbeat and leaves any heartbeat already in progress unchanged.
- R8: An end of transmission that occurs while `tx_inhibit` is 1, including the end of a burst that tripped the lockout, produces no heartbeat.
- R9: An eligible end of transmission that arrives while a heartbeat is pending or active starts the heartbeat timing over from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC |
| full_duplex | input | 1 | 1 = full duplex, so no heartbeat is produced |
| col | output | 1 | Collision indication: heartbeat pulse or lockout |
| tx_inhibit | output | 1 | Blocks the line driver while the lockout is active |

## Verification
The assertions assume that `tx_en` and `full_duplex` are synchronous to `clk` and change only between edges. The stimulus meets this by driving both inputs on the falling clock edge. The assertions also assume that nothing but a run of high `tx_en` samples raises the lockout, and that nothing but a low sample or a reset releases it. The random stimulus mixes bursts that are shorter and longer than the trip limit with quiet gaps on either side of the release limit. It selects full duplex on about a quarter of the frames, and it deliberately places some frame ends inside a heartbeat that is still running.

// File: rtl/jtx_pkg.sv
package jtx_pkg;
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_e;
endpackage

// File: rtl/jtx_tick_gen.sv
module jtx_tick_gen #(
    parameter int TICK_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] cnt_d, cnt_q;
            always_comb begin
                cnt_d = (cnt_q == DW'(TICK_DIV - 1)) ? '0 : cnt_q + 1'b1;
            end
            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end
            assign tick = (cnt_q == DW'(TICK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/jtx_jabber.sv
module jtx_jabber #(
    parameter int TRIP_TICKS = 850000,
    parameter int REL_TICKS  = 5000000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic tx_en,
    output logic locked
);
    localparam int MAXT = (TRIP_TICKS > REL_TICKS) ? TRIP_TICKS : REL_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic          lock;
        logic [CW-1:0] cnt;
    } jab_st_t;

    jab_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.lock) begin
            if (!tx_en) begin
                st_d.cnt = '0;
            end else if (tick) begin
                if (st_q.cnt == CW'(TRIP_TICKS - 1)) begin
                    st_d.lock = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            if (tx_en) begin
                st_d.cnt = '0;
            end else if (tick) begin
                if (st_q.cnt == CW'(REL_TICKS - 1)) begin
                    st_d.lock = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign locked = st_q.lock;
endmodule

// File: rtl/jtx_heartbeat.sv
module jtx_heartbeat
    import jtx_pkg::*;
#(
    parameter int DLY_TICKS = 6,
    parameter int LEN_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic tx_en,
    input  logic full_duplex,
    input  logic jab_active,
    output logic pulse
);
    localparam int MAXT = (DLY_TICKS > LEN_TICKS) ? DLY_TICKS : LEN_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        hb_state_e     state;
        logic [CW-1:0] cnt;
        logic          tx_prev;
    } hb_st_t;

    hb_st_t st_d, st_q;
    logic   frame_end;

    always_comb begin
        frame_end = st_q.tx_prev & ~tx_en & ~full_duplex & ~jab_active;
        st_d = st_q;
        st_d.tx_prev = tx_en;
        unique case (st_q.state)
            HB_WAIT: if (tick) begin
                if (st_q.cnt == CW'(DLY_TICKS - 1)) begin
                    st_d.state = HB_PULSE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            HB_PULSE: if (tick) begin
                if (st_q.cnt == CW'(LEN_TICKS - 1)) begin
                    st_d.state = HB_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.cnt = '0;
        endcase
        if (frame_end) begin
            st_d.state = HB_WAIT;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{state: HB_IDLE, cnt: '0, tx_prev: 1'b0};
        else     st_q <= st_d;
    end

    assign pulse = (st_q.state == HB_PULSE);
endmodule

// File: rtl/jtx_supervisor.sv
module jtx_supervisor #(
    parameter int TICK_DIV       = 10,
    parameter int JAB_TRIP_TICKS = 850000,
    parameter int JAB_REL_TICKS  = 5000000,
    parameter int HB_DLY_TICKS   = 6,
    parameter int HB_LEN_TICKS   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic full_duplex,
    output logic col,
    output logic tx_inhibit
);
    logic tick;
    logic jab_locked;
    logic hb_pulse;

    jtx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    jtx_jabber #(
        .TRIP_TICKS(JAB_TRIP_TICKS),
        .REL_TICKS (JAB_REL_TICKS)
    ) u_jab (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .tx_en (tx_en),
        .locked(jab_locked)
    );

    jtx_heartbeat #(
        .DLY_TICKS(HB_DLY_TICKS),
        .LEN_TICKS(HB_LEN_TICKS)
    ) u_hb (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tx_en      (tx_en),
        .full_duplex(full_duplex),
        .jab_active (jab_locked),
        .pulse      (hb_pulse)
    );

    assign tx_inhibit = jab_locked;
    assign col        = jab_locked | hb_pulse;
endmodule

// File: rtl/jtx_supervisor_chk.sv
module jtx_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic full_duplex,
    input logic col,
    input logic tx_inhibit
);
    AST_INHIBIT_HOLDS_COL: assert property (@(posedge clk) disable iff (rst)
        tx_inhibit |-> col); // R4

    AST_TRIP_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_inhibit) |-> $past(tx_en)); // R2

    AST_RELEASE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_inhibit) && !$past(rst)) |-> !$past(tx_en)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!col && !tx_inhibit)); // R1

    AST_MODE_INPUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({tx_en, full_duplex})); // R6
endmodule

bind jtx_supervisor jtx_supervisor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .full_duplex(full_duplex),
    .col        (col),
    .tx_inhibit (tx_inhibit)
);

// File: tb/jtx_supervisor_tb.sv
module jtx_supervisor_tb;
    localparam int TRIP = 40;
    localparam int REL  = 60;
    localparam int DLY  = 8;
    localparam int LEN  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0;
    logic full_duplex = 1'b0;
    logic col, tx_inhibit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state
    int  n = 0;
    int  run_hi = 0;
    int  run_lo = 0;
    bit  m_jab = 1'b0;
    bit  m_prev = 1'b0;
    bit  hb_ok = 1'b0;
    int  hb_at = 0;

    always #5 clk = ~clk;

    jtx_supervisor #(
        .TICK_DIV      (1),
        .JAB_TRIP_TICKS(TRIP),
        .JAB_REL_TICKS (REL),
        .HB_DLY_TICKS  (DLY),
        .HB_LEN_TICKS  (LEN)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .full_duplex(full_duplex),
        .col        (col),
        .tx_inhibit (tx_inhibit)
    );

    function automatic bit exp_hb(int now, int at, bit ok);
        return ok && (now - at >= DLY) && (now - at < DLY + LEN);
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual=%0b expected=%0b", tag, what, n, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_jab = 0; run_hi = 0; run_lo = 0; m_prev = 0; hb_ok = 0; n++;
        check("R1", "col", col, 1'b0);
        check("R1", "tx_inhibit", tx_inhibit, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(bit tx, bit fd, string tag_i, string tag_c);
        bit jab_before;
        @(negedge clk);
        tx_en = tx;
        full_duplex = fd;
        @(posedge clk);
        #1;
        n++;
        jab_before = m_jab;
        if (m_prev && !tx && !fd && !jab_before) begin
            hb_ok = 1'b1;
            hb_at = n;
        end
        if (!m_jab) begin
            if (tx) begin
                run_hi++;
                if (run_hi == TRIP) begin m_jab = 1'b1; run_lo = 0; end
            end else begin
                run_hi = 0;
            end
        end else begin
            if (tx) run_lo = 0;
            else begin
                run_lo++;
                if (run_lo == REL) begin m_jab = 1'b0; run_hi = 0; end
            end
        end
        m_prev = tx;
        check(tag_i, "tx_inhibit", tx_inhibit, m_jab);
        check(m_jab ? "R4" : tag_c, "col", col, m_jab | exp_hb(n, hb_at, hb_ok));
    endtask

    task automatic burst(int hi, int lo, bit fd, string ti, string tc);
        for (int i = 0; i < hi; i++) step(1'b1, fd, ti, tc);
        for (int i = 0; i < lo; i++) step(1'b0, fd, ti, tc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        do_reset();
        // R6: plain half-duplex frame and heartbeat
        burst(12, 30, 1'b0, "R3", "R6");
        // R7: full-duplex frame, no pulse
        burst(12, 30, 1'b1, "R3", "R7");
        // R3: one short of trip, split by a single low, then short again
        burst(TRIP - 1, 1, 1'b1, "R3", "R7");
        burst(TRIP - 1, 25, 1'b1, "R3", "R7");
        // R2 + R8: exact trip, ending inside lockout gives no pulse
        burst(TRIP, 20, 1'b0, "R2", "R8");
        // R5: high sample at REL-1 lows restarts release count
        burst(1, REL - 1, 1'b0, "R5", "R8");
        burst(1, REL + 5, 1'b0, "R5", "R8");
        // R9: eligible end during pending heartbeat restarts it
        burst(5, 4, 1'b0, "R3", "R9");
        burst(3, 12, 1'b0, "R3", "R9");
        // R7: full-duplex end during active pulse leaves it untouched
        burst(5, DLY + 2, 1'b0, "R3", "R6");
        burst(2, 20, 1'b1, "R3", "R7");
        // R1: reset in the middle of a heartbeat and of a lockout
        burst(6, DLY + 3, 1'b0, "R3", "R6");
        do_reset();
        burst(4, 20, 1'b0, "R3", "R6");
        burst(TRIP + 3, 5, 1'b0, "R2", "R8");
        do_reset();
        burst(0, 5, 1'b0, "R1", "R1");
        // random mix
        for (int k = 0; k < 80; k++) begin
            int hi = $urandom_range(1, TRIP + 10);
            int lo = $urandom_range(1, REL + 30);
            bit fd = ($urandom_range(0, 3) == 0);
            burst(hi, lo, fd, "R2", "R6");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule